// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Configuration-Aware Instruction Gating

This block is the serial test port of a chip. It uses three inputs: a test clock, a mode-select line and a serial data input. It has one serial data output, and that output has its own output-enable. There is no separate test-reset pin. A 16-state controller follows the mode-select line on every rising test-clock edge. It moves data through one of two paths. The first is a 6-bit instruction register. The second is the data register that the current instruction selects. The block holds three data registers of its own: a 1-bit bypass stage, a 32-bit identification register, and a 32-bit user-code register that is loaded from an input bus. The boundary register and four user data registers sit outside the block. For these the block supplies capture, shift and update strobes, select lines and a serial return path.

The instruction that takes effect depends on two status inputs. The four user instructions are refused until the device reports that it is configured. The three instructions that use the boundary register are refused while configuration is running. A refused instruction, or an opcode the block does not know, behaves as bypass. A refusal also sets a sticky flag, which only the reset state clears. The controller can be reset in two ways only: by the power-on reset, or by walking it to its reset state with the mode-select line.

Top module: `scan_tap`

## Requirements
- R1: The controller has 16 states and advances on each rising test-clock edge using the mode-select value at that edge. Five rising edges with mode-select high bring it to the reset state from any state.
- R2: The power-on reset (active high, sampled on test-clock edges) puts the controller in the reset state. While the controller is in the reset state, the active instruction becomes IDCODE (6'h09) and the sticky reject flag is cleared.
- R3: In Capture-IR the 6-bit instruction shift register loads 6'b000001. In Shift-IR it shifts toward the output with bit 0 first, and the serial input enters at bit 5.
- R4: The serial output and its enable change on the falling test-clock edge. The enable is high only in Shift-IR and Shift-DR.
- R5: A new instruction takes effect on the falling edge in Update-IR. The decoded outputs (select lines, pin-mode enables, reject flag) do not change while an instruction is being shifted.
- R6: BYPASS (6'h3F) selects a 1-bit register that captures 0, so shifted data emerges one clock late behind a leading 0. An opcode outside the decoded set also selects bypass and does not set the reject flag.
- R7: IDCODE (6'h09) captures the 32-bit identification value in Capture-DR and shifts it out bit 0 first.
- R8: USERCODE (6'h08) captures the 32-bit user-code input in Capture-DR and shifts it out bit 0 first.
- R9: USER1..USER4 (6'h02, 6'h03, 6'h22, 6'h23) with the configured flag low decode to bypass and set the reject flag. With the flag high they raise usr_sel bit k-1 (one-hot), and the serial output returns usr_tdo bit k-1.
- R10: EXTEST (6'h00), SAMPLE/PRELOAD (6'h01) and INTEST (6'h07) raise bsr_sel and return bsr_tdo. EXTEST also raises extest_en, and INTEST raises intest_en. While cfg_busy is high at Update-IR they decode to bypass, set the reject flag, and leave all of these outputs low.
- R11: HIGHZ (6'h0A) raises highz_en and selects the bypass register.
- R12: Once set, the reject flag stays set across later instruction loads until the controller enters the reset state.
- R13: dr_capture, dr_shift and dr_update are high exactly in Capture-DR, Shift-DR and Update-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data input |
| tdo | output | 1 | Serial data output, updated on falling tck |
| tdo_en | output | 1 | Output enable for tdo; low means high-impedance |
| cfg_done | input | 1 | Device configured flag |
| cfg_busy | input | 1 | Configuration in progress flag |
| user_code | input | 32 | Value captured by USERCODE |
| dr_capture | output | 1 | Controller is in Capture-DR |
| dr_shift | output | 1 | Controller is in Shift-DR |
| dr_update | output | 1 | Controller is in Update-DR |
| bsr_sel | output | 1 | Boundary register selected |
| bsr_tdo | input | 1 | Serial return from the boundary register |
| usr_sel | output | 4 | One-hot select of user data registers |
| usr_tdo | input | 4 | Serial returns of user data registers |
| extest_en | output | 1 | External-test pin mode active |
| intest_en | output | 1 | Internal-test mode active |
| highz_en | output | 1 | All pins to high-impedance |
| ir_reject | output | 1 | Sticky flag: a loaded instruction was refused |

## Verification
The bench builds the block with a non-default identification value, 32'h3B0CA0D5, and keeps the 32-bit data width. The full identification capture is therefore compared against a pattern that the reset default cannot produce, and a full-length shift of both 32-bit registers stays within a short run. With the width at its default, every scan covers the real register length. Short 8-bit scans through bypass, the boundary return and the user returns separate a one-cycle bypass delay from a direct return. The two status inputs are switched between instruction loads so that both gating conditions are reached, along with their release.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;
  typedef enum logic [3:0] {
    TS_RESET = 4'h0, TS_IDLE, TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR,
    TS_PAU_DR, TS_EX2_DR, TS_UPD_DR, TS_SEL_IR, TS_CAP_IR, TS_SH_IR,
    TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_t;

  localparam int IR_W   = 6;
  localparam int N_USER = 4;
  typedef logic [IR_W-1:0] opc_t;

  localparam opc_t OP_EXTEST   = 6'h00;
  localparam opc_t OP_SAMPLE   = 6'h01;
  localparam opc_t OP_USER1    = 6'h02;
  localparam opc_t OP_USER2    = 6'h03;
  localparam opc_t OP_INTEST   = 6'h07;
  localparam opc_t OP_USERCODE = 6'h08;
  localparam opc_t OP_IDCODE   = 6'h09;
  localparam opc_t OP_HIGHZ    = 6'h0A;
  localparam opc_t OP_USER3    = 6'h22;
  localparam opc_t OP_USER4    = 6'h23;
  localparam opc_t OP_BYPASS   = 6'h3F;
  localparam opc_t IR_CAPTURE  = 6'b000001;

  function automatic logic [N_USER-1:0] user_onehot(opc_t op);
    case (op)
      OP_USER1: return 4'b0001;
      OP_USER2: return 4'b0010;
      OP_USER3: return 4'b0100;
      OP_USER4: return 4'b1000;
      default:  return '0;
    endcase
  endfunction

  function automatic logic uses_bsr(opc_t op);
    return (op == OP_EXTEST) || (op == OP_SAMPLE) || (op == OP_INTEST);
  endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       por,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t nxt;

  always_comb begin
    case (state)
      TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
      default:   nxt = tms ? TS_SEL_DR : TS_IDLE;
    endcase
  end

  always_ff @(posedge tck) begin
    if (por) state <= TS_RESET;
    else     state <= nxt;
  end

  // R1: five consecutive high mode-select samples always end in reset
  assert_five_ones_reset_R1: assert property (@(posedge tck) disable iff (por)
    ($past(tms,1) && $past(tms,2) && $past(tms,3) && $past(tms,4) && $past(tms,5))
      |-> (state == TS_RESET));
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import scan_tap_pkg::*;
(
  input  logic              tck,
  input  logic              por,
  input  logic              tdi,
  input  tap_state_t        state,
  input  logic              cfg_done,
  input  logic              cfg_busy,
  output logic              ir_tdo,
  output logic              sel_id,
  output logic              sel_uc,
  output logic              bsr_sel,
  output logic [N_USER-1:0] usr_sel,
  output logic              extest_en,
  output logic              intest_en,
  output logic              highz_en,
  output logic              reject
);
  opc_t ir_sr, instr, eff_op;
  logic known, blocked;

  always_ff @(posedge tck) begin
    if (por)                     ir_sr <= IR_CAPTURE;
    else if (state == TS_CAP_IR) ir_sr <= IR_CAPTURE;
    else if (state == TS_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end
  assign ir_tdo = ir_sr[0];

  always_comb begin
    known = (|user_onehot(ir_sr)) || uses_bsr(ir_sr) || (ir_sr == OP_BYPASS) ||
            (ir_sr == OP_IDCODE) || (ir_sr == OP_USERCODE) || (ir_sr == OP_HIGHZ);
    blocked = ((|user_onehot(ir_sr)) && !cfg_done) || (uses_bsr(ir_sr) && cfg_busy);
    eff_op = (!known || blocked) ? OP_BYPASS : ir_sr;
  end

  always_ff @(negedge tck) begin
    if (por || state == TS_RESET) begin
      instr  <= OP_IDCODE;
      reject <= 1'b0;
    end else if (state == TS_UPD_IR) begin
      instr  <= eff_op;
      reject <= reject | (known && blocked);
    end
  end

  assign sel_id    = (instr == OP_IDCODE);
  assign sel_uc    = (instr == OP_USERCODE);
  assign bsr_sel   = uses_bsr(instr);
  assign usr_sel   = user_onehot(instr);
  assign extest_en = (instr == OP_EXTEST);
  assign intest_en = (instr == OP_INTEST);
  assign highz_en  = (instr == OP_HIGHZ);

  // R3: capture loads the fixed pattern
  assert_ir_capture_R3: assert property (@(posedge tck) disable iff (por)
    (state == TS_CAP_IR) |=> (ir_sr == IR_CAPTURE));
  // R5: active instruction only moves at update or reset
  assert_instr_stable_R5: assert property (@(negedge tck) disable iff (por)
    (state != TS_UPD_IR && state != TS_RESET) |=> $stable(instr));
  // R9: at most one user register selected
  assert_usr_onehot_R9: assert property (@(posedge tck) disable iff (por)
    $onehot0(usr_sel));
  // R9: unconfigured update never selects a user register
  assert_user_gate_R9: assert property (@(negedge tck) disable iff (por)
    (state == TS_UPD_IR && !cfg_done) |=> (usr_sel == '0));
  // R10: busy update never selects the boundary register
  assert_bsr_gate_R10: assert property (@(negedge tck) disable iff (por)
    (state == TS_UPD_IR && cfg_busy) |=> !bsr_sel);
  // R12: reset state leaves the flag clear
  assert_reject_clear_R12: assert property (@(posedge tck) disable iff (por)
    (state == TS_RESET) |-> !reject);
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import scan_tap_pkg::*;
#(
  parameter int              DR_W     = 32,
  parameter logic [DR_W-1:0] ID_VALUE = 32'h0000_0001
) (
  input  logic              tck,
  input  logic              por,
  input  logic              tdi,
  input  tap_state_t        state,
  input  logic              sel_id,
  input  logic              sel_uc,
  input  logic              bsr_sel,
  input  logic [N_USER-1:0] usr_sel,
  input  logic [DR_W-1:0]   user_code,
  input  logic              bsr_tdo,
  input  logic [N_USER-1:0] usr_tdo,
  output logic              dr_tdo
);
  logic [DR_W-1:0] sr;
  logic            byp_q;
  logic            sel_wide;

  assign sel_wide = sel_id | sel_uc;

  always_ff @(posedge tck) begin
    if (por) begin
      sr    <= ID_VALUE;
      byp_q <= 1'b0;
    end else begin
      if (state == TS_CAP_DR) byp_q <= 1'b0;
      else if (state == TS_SH_DR) byp_q <= tdi;
      if (sel_wide && state == TS_CAP_DR) sr <= sel_uc ? user_code : ID_VALUE;
      else if (sel_wide && state == TS_SH_DR) sr <= {tdi, sr[DR_W-1:1]};
    end
  end

  always_comb begin
    if (sel_wide)        dr_tdo = sr[0];
    else if (bsr_sel)    dr_tdo = bsr_tdo;
    else if (|usr_sel)   dr_tdo = |(usr_sel & usr_tdo);
    else                 dr_tdo = byp_q;
  end

  // R7: identification capture yields the configured value
  assert_id_capture_R7: assert property (@(posedge tck) disable iff (por)
    (state == TS_CAP_DR && sel_id) |=> (sr == ID_VALUE));
  // R6: bypass stage holds 0 right after capture
  assert_bypass_zero_R6: assert property (@(posedge tck) disable iff (por)
    (state == TS_CAP_DR) |=> !byp_q);
endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int              DR_W     = 32,
  parameter logic [DR_W-1:0] ID_VALUE = 32'h1A5C_E093
) (
  input  logic              tck,
  input  logic              por,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_en,
  input  logic              cfg_done,
  input  logic              cfg_busy,
  input  logic [DR_W-1:0]   user_code,
  output logic              dr_capture,
  output logic              dr_shift,
  output logic              dr_update,
  output logic              bsr_sel,
  input  logic              bsr_tdo,
  output logic [N_USER-1:0] usr_sel,
  input  logic [N_USER-1:0] usr_tdo,
  output logic              extest_en,
  output logic              intest_en,
  output logic              highz_en,
  output logic              ir_reject
);
  tap_state_t state;
  logic ir_tdo, dr_tdo, sel_id, sel_uc;

  tap_fsm u_fsm (.tck(tck), .por(por), .tms(tms), .state(state));

  tap_ir u_ir (
    .tck(tck), .por(por), .tdi(tdi), .state(state),
    .cfg_done(cfg_done), .cfg_busy(cfg_busy), .ir_tdo(ir_tdo),
    .sel_id(sel_id), .sel_uc(sel_uc), .bsr_sel(bsr_sel), .usr_sel(usr_sel),
    .extest_en(extest_en), .intest_en(intest_en), .highz_en(highz_en),
    .reject(ir_reject)
  );

  tap_dr #(.DR_W(DR_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .por(por), .tdi(tdi), .state(state),
    .sel_id(sel_id), .sel_uc(sel_uc), .bsr_sel(bsr_sel), .usr_sel(usr_sel),
    .user_code(user_code), .bsr_tdo(bsr_tdo), .usr_tdo(usr_tdo),
    .dr_tdo(dr_tdo)
  );

  always_ff @(negedge tck) begin
    if (por) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state == TS_SH_IR) || (state == TS_SH_DR);
      tdo    <= (state == TS_SH_IR) ? ir_tdo : dr_tdo;
    end
  end

  assign dr_capture = (state == TS_CAP_DR);
  assign dr_shift   = (state == TS_SH_DR);
  assign dr_update  = (state == TS_UPD_DR);

  // R4: output enabled only in a shift state
  assert_tdo_en_shift_R4: assert property (@(posedge tck) disable iff (por)
    tdo_en |-> (state == TS_SH_IR || state == TS_SH_DR));
  assert_tdo_en_seen_R4: assert property (@(posedge tck) disable iff (por)
    (state == TS_SH_IR || state == TS_SH_DR) |-> tdo_en);
  // R10: boundary and user selects never coexist
  assert_sel_exclusive_R10: assert property (@(posedge tck) disable iff (por)
    !(bsr_sel && (|usr_sel)));
endmodule

// File: tb/scan_tap_bench.sv
module scan_tap_bench;
  import scan_tap_pkg::*;
  localparam logic [31:0] IDV = 32'h3B0C_A0D5;
  localparam logic [31:0] UCV = 32'hC0DE_5A17;

  logic tck = 1'b0, por = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic cfg_done = 1'b0, cfg_busy = 1'b0, bsr_tdo = 1'b0;
  logic [3:0] usr_tdo = 4'b0000;
  logic tdo, tdo_en, dr_capture, dr_shift, dr_update, bsr_sel;
  logic extest_en, intest_en, highz_en, ir_reject;
  logic [3:0] usr_sel;
  int checks = 0, errors = 0;
  logic saw_cap, saw_upd, shift_ok, stab_ok;

  always #10 tck = ~tck;

  scan_tap #(.DR_W(32), .ID_VALUE(IDV)) u_scan_tap (
    .tck(tck), .por(por), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .cfg_done(cfg_done), .cfg_busy(cfg_busy), .user_code(UCV),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
    .bsr_sel(bsr_sel), .bsr_tdo(bsr_tdo), .usr_sel(usr_sel), .usr_tdo(usr_tdo),
    .extest_en(extest_en), .intest_en(intest_en), .highz_en(highz_en),
    .ir_reject(ir_reject)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #2;
  endtask

  task automatic to_reset_idle();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic ir_scan(input opc_t op, output opc_t cap);
    logic [8:0] snap;
    cap = '0; stab_ok = 1'b1;
    snap = {highz_en, extest_en, intest_en, bsr_sel, usr_sel, ir_reject};
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < IR_W; i++) begin
      cap[i] = tdo;
      if ({highz_en, extest_en, intest_en, bsr_sel, usr_sel, ir_reject} !== snap) stab_ok = 1'b0;
      step(i == IR_W-1, op[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic dr_scan(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0; shift_ok = 1'b1;
    step(1, 0); step(0, 0); saw_cap = dr_capture; step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      if (!tdo_en || !dr_shift) shift_ok = 1'b0;
      step(i == n-1, din[i]);
    end
    step(1, 0); saw_upd = dr_update; step(0, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R2 reject after por", ir_reject, 0);
    chk("R4 tdo_en idle", tdo_en, 0);
    dr_scan(32, 32'h0, d);
    chk("R7 R2 idcode after por", d, IDV);
    chk("R13 capture strobe", saw_cap, 1);
    chk("R13 update strobe", saw_upd, 1);
    chk("R4 R13 shift enable", shift_ok, 1);
  endtask

  task automatic t_bypass();
    opc_t c; logic [31:0] d;
    ir_scan(OP_BYPASS, c);
    chk("R3 capture pattern", c, 6'b000001);
    chk("R4 tdo_en off after ir", tdo_en, 0);
    dr_scan(8, 32'hA5, d);
    chk("R6 bypass delay", d[7:0], {8'hA5 << 1} & 8'hFE);
  endtask

  task automatic t_usercode();
    opc_t c; logic [31:0] d;
    ir_scan(OP_USERCODE, c);
    dr_scan(32, 32'h0, d);
    chk("R8 usercode", d, UCV);
  endtask

  task automatic t_unknown();
    opc_t c; logic [31:0] d;
    ir_scan(6'h15, c);
    chk("R6 unknown no reject", ir_reject, 0);
    dr_scan(8, 32'h3C, d);
    chk("R6 unknown bypass", d[7:0], 8'h78);
  endtask

  task automatic t_user_gated();
    opc_t c; logic [31:0] d;
    cfg_done = 1'b0;
    ir_scan(OP_USER1, c);
    chk("R9 gated reject", ir_reject, 1);
    chk("R9 gated usr_sel", usr_sel, 0);
    usr_tdo = 4'b1111;
    dr_scan(8, 32'hFF, d);
    chk("R9 gated bypass", d[7:0], 8'hFE);
    ir_scan(OP_IDCODE, c);
    chk("R12 sticky reject", ir_reject, 1);
    to_reset_idle();
    chk("R12 cleared by reset", ir_reject, 0);
    usr_tdo = 4'b0000;
    dr_scan(32, 32'h0, d);
    chk("R2 idcode after walk", d, IDV);
  endtask

  task automatic t_user_ok();
    opc_t c; logic [31:0] d;
    cfg_done = 1'b1;
    ir_scan(OP_USER3, c);
    chk("R9 user3 select", usr_sel, 4'b0100);
    chk("R9 user3 no reject", ir_reject, 0);
    usr_tdo = 4'b0100;
    dr_scan(8, 32'h00, d);
    chk("R9 user3 return", d[7:0], 8'hFF);
    chk("R13 strobes user", {saw_cap, saw_upd, shift_ok}, 3'b111);
    usr_tdo = 4'b0000;
  endtask

  task automatic t_bsr();
    opc_t c; logic [31:0] d;
    cfg_busy = 1'b1;
    ir_scan(OP_EXTEST, c);
    chk("R10 busy reject", ir_reject, 1);
    chk("R10 busy outputs low", {bsr_sel, extest_en}, 2'b00);
    to_reset_idle();
    cfg_busy = 1'b0;
    ir_scan(OP_EXTEST, c);
    chk("R10 extest", {bsr_sel, extest_en, intest_en}, 3'b110);
    bsr_tdo = 1'b1;
    dr_scan(8, 32'h00, d);
    chk("R10 bsr return", d[7:0], 8'hFF);
    ir_scan(OP_INTEST, c);
    chk("R5 stable during shift", stab_ok, 1);
    chk("R10 intest", {bsr_sel, extest_en, intest_en}, 3'b101);
    ir_scan(OP_SAMPLE, c);
    chk("R10 sample", {bsr_sel, extest_en, intest_en}, 3'b100);
    bsr_tdo = 1'b0;
  endtask

  task automatic t_highz();
    opc_t c; logic [31:0] d;
    ir_scan(OP_HIGHZ, c);
    chk("R11 highz_en", highz_en, 1);
    dr_scan(8, 32'h81, d);
    chk("R11 highz bypass", d[7:0], 8'h02);
  endtask

  task automatic t_walk_from_shift();
    logic [31:0] d;
    step(1, 0); step(0, 0); step(0, 0);
    chk("R1 in shift", tdo_en, 1);
    to_reset_idle();
    chk("R1 highz cleared", highz_en, 0);
    dr_scan(32, 32'h0, d);
    chk("R1 idcode after walk", d, IDV);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge tck);
    #2 por = 1'b0;
    step(1'b0, 1'b0);
    t_reset();
    t_bypass();
    t_usercode();
    t_unknown();
    t_user_gated();
    t_user_ok();
    t_bsr();
    t_highz();
    t_walk_from_shift();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule